// File: doc/BRIEF.md
# Serial Flash Instruction Front End

This block is the serial-side front end of a flash device model or controller. It is an SPI slave that works in clock mode 0 or 3. SI is taken on the rising SCK edge and SO changes on the falling edge, most significant bit first. It receives an 8-bit instruction code and, where needed, a 24-bit address. From these it produces one of two things. The first is a continuous output stream: array data, status, or an identification code. The second is a decoded command strobe that a back end executes.

The serial pins are asynchronous to the block clock. They are synchronised and edge-detected inside, so SCK must stay well below a quarter of the block clock rate. Array data comes from a byte-wide read port: the block presents an address pointer and the back end returns the byte combinationally. Status comes in as a byte from the back end; its bit 0 is the busy flag. A pause input suspends a transfer without losing its place. The pause takes effect only while SCK is low.

Top module: `spif_frontend`

## Requirements
- R1: Opcode 03h followed by a 3-byte address streams array bytes from that address. The first data bit appears after the falling edge that ends the last address bit, and the pointer increments after each byte.
- R2: The array pointer is ADDR_W bits wide. After the top address (7FFFFh by default) the stream continues at 00000h.
- R3: Opcode 0Bh behaves as R1, except that one dummy byte of 8 clocks follows the address before data starts.
- R4: Opcode 05h outputs the status_in byte. It repeats once per 8 clocks, re-sampled at each byte start, until CS rises.
- R5: Opcode 9Fh outputs 8Ch, 20h, 13h in that order, and 00h for every later byte.
- R6: Opcode 90h plus a 3-byte address outputs 8Ch when address bit 0 is 0 and 12h when it is 1. It then alternates between the two until CS rises.
- R7: Opcode ABh works as R6 when status_in[0] is 0. When status_in[0] is 1 it is not decoded: SO stays undriven and no command is issued.
- R8: Write-type instructions produce a one-cycle cmd_valid only on the CS rising edge, and only when the final bit has been received. The cmd_op encoding is 1 06h, 2 04h, 3 50h, 4 01h+1 data byte, 5 02h+addr+1 byte, 6 ADh+addr+2 bytes, 7 20h+addr, 8 D8h+addr, 9 60h or C7h, 10 70h, 11 80h. cmd_data holds the single data byte zero-extended, or the two AAI bytes with the first byte in [15:8].
- R9: A CS rise before the final bit of an instruction issues nothing. Any SCK rising edge after the final bit of a write-type instruction also cancels it.
- R10: An unknown opcode is ignored until CS rises: no output and no command.
- R11: The pause state starts when hold_n is low while SCK is low, and ends when hold_n is high while SCK is low. A change of hold_n while SCK is high takes effect at the next SCK low. While paused, SO is undriven and SCK/SI edges are ignored, so the transfer resumes in place.
- R12: A CS rise during a pause clears the pause and all sequence state, so the next instruction decodes from its first bit.
- R13: so_oe is 0 after reset, whenever CS is high, and whenever no output phase is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_si | input | 1 | Serial data in |
| spi_hold_n | input | 1 | Pause request, active low |
| so_out | output | 1 | Serial data out value |
| so_oe | output | 1 | Serial data out drive enable |
| mem_addr | output | ADDR_W | Array read address |
| mem_rd | output | 1 | Array read phase active |
| mem_rdata | input | 8 | Array byte at mem_addr |
| status_in | input | 8 | Status byte, bit 0 busy |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_op | output | 4 | Decoded command code |
| cmd_addr | output | 24 | Captured address |
| cmd_data | output | 16 | Captured data byte(s) |

## Verification
The bench targets the address wrap at the top of the array. A design that saturated or overran there would repeat the last byte or present a bad address. It checks the fast-read dummy byte, which a design could skip or count twice and so shift the data by eight bits. It checks that the identification alternation starts from the address LSB and that a busy device refuses the signature read. It also checks the two pause entry cases: a pause applied while SCK is high must not take effect until SCK falls, and a pause applied mid-byte must resume with no bit lost. Aborted, over-clocked and unknown instructions are checked for the absence of any strobe, which catches a design that executes on the last bit rather than on the CS edge.

// File: rtl/spif_pkg.sv
package spif_pkg;
  localparam logic [7:0] C_READ  = 8'h03;
  localparam logic [7:0] C_FREAD = 8'h0B;
  localparam logic [7:0] C_SECT  = 8'h20;
  localparam logic [7:0] C_BLK   = 8'hD8;
  localparam logic [7:0] C_CHIPA = 8'h60;
  localparam logic [7:0] C_CHIPB = 8'hC7;
  localparam logic [7:0] C_PROG  = 8'h02;
  localparam logic [7:0] C_AAI   = 8'hAD;
  localparam logic [7:0] C_RDST  = 8'h05;
  localparam logic [7:0] C_EWST  = 8'h50;
  localparam logic [7:0] C_WRST  = 8'h01;
  localparam logic [7:0] C_WEN   = 8'h06;
  localparam logic [7:0] C_WDIS  = 8'h04;
  localparam logic [7:0] C_SIG   = 8'hAB;
  localparam logic [7:0] C_JID   = 8'h9F;
  localparam logic [7:0] C_RID   = 8'h90;
  localparam logic [7:0] C_EBSY  = 8'h70;
  localparam logic [7:0] C_DBSY  = 8'h80;

  typedef enum logic [2:0] {
    PH_OPC, PH_ADDR, PH_DUMMY, PH_DIN, PH_OUT, PH_DONE, PH_IGN
  } phase_e;

  typedef enum logic [1:0] {SRC_MEM, SRC_STAT, SRC_JID, SRC_RID} src_e;

  typedef enum logic [3:0] {
    OP_NONE = 4'd0, OP_WEN = 4'd1, OP_WDIS = 4'd2, OP_EWST = 4'd3,
    OP_WRST = 4'd4, OP_PROG = 4'd5, OP_AAI = 4'd6, OP_SECT = 4'd7,
    OP_BLK = 4'd8, OP_CHIP = 4'd9, OP_EBSY = 4'd10, OP_DBSY = 4'd11
  } op_e;
endpackage

// File: rtl/spif_sync.sv
module spif_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/spif_hold.sv
module spif_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_s,
  input  logic sck_s,
  input  logic hold_n_s,
  output logic paused,
  output logic hold_q
);
  // The pause state may only change while SCK is low; CS high clears it.
  always_comb begin
    if (cs_n_s)      paused = 1'b0;
    else if (!sck_s) paused = ~hold_n_s;
    else             paused = hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= paused;
  end
endmodule

// File: rtl/spif_outsel.sv
module spif_outsel
  import spif_pkg::*;
(
  input  src_e       src,
  input  logic [7:0] mem_rdata,
  input  logic [7:0] status,
  input  logic       rid_odd,
  input  logic [1:0] jidx,
  output logic [7:0] obyte
);
  logic [7:0] jbyte;

  always_comb begin
    case (jidx)
      2'd0:    jbyte = 8'h8C;
      2'd1:    jbyte = 8'h20;
      2'd2:    jbyte = 8'h13;
      default: jbyte = 8'h00;
    endcase
    case (src)
      SRC_MEM:  obyte = mem_rdata;
      SRC_STAT: obyte = status;
      SRC_JID:  obyte = jbyte;
      default:  obyte = rid_odd ? 8'h12 : 8'h8C;
    endcase
  end
endmodule

// File: rtl/spif_frontend.sv
module spif_frontend
  import spif_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_si,
  input  logic              spi_hold_n,
  output logic              so_out,
  output logic              so_oe,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  input  logic [7:0]        mem_rdata,
  input  logic [7:0]        status_in,
  output logic              cmd_valid,
  output logic [3:0]        cmd_op,
  output logic [23:0]       cmd_addr,
  output logic [15:0]       cmd_data
);
  localparam int AB = 3;

  logic cs_n_s, sck_s, hold_n_s, si_s;
  logic paused, hold_q;

  spif_sync #(.W(4), .RST_VAL(4'b1010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({spi_cs_n, spi_sck, spi_hold_n, spi_si}),
    .q({cs_n_s, sck_s, hold_n_s, si_s})
  );

  spif_hold u_hold (
    .clk(clk), .rst_n(rst_n), .cs_n_s(cs_n_s), .sck_s(sck_s),
    .hold_n_s(hold_n_s), .paused(paused), .hold_q(hold_q)
  );

  phase_e phase_q, phase_d;
  src_e   src_q, src_d;
  op_e    pend_q, pend_d, cop_q, cop_d;
  logic [2:0]        bit_q, bit_d, ocnt_q, ocnt_d;
  logic [1:0]        byte_q, byte_d, jidx_q, jidx_d;
  logic [7:0]        sh_q, sh_d, opc_q, opc_d, osh_q, osh_d;
  logic [23:0]       addr_q, addr_d, caddr_q, caddr_d;
  logic [15:0]       data_q, data_d, cdata_q, cdata_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              so_q, so_d, cv_q, cv_d, sck_q, cs_q;

  logic        rise, fall, cs_rise;
  logic [7:0]  inbyte, obyte;
  logic [23:0] addr_nx;

  assign rise    = sck_s & ~sck_q & ~cs_n_s & ~paused;
  assign fall    = ~sck_s & sck_q & ~cs_n_s & ~paused;
  assign cs_rise = cs_n_s & ~cs_q;
  assign inbyte  = {sh_q[6:0], si_s};
  assign addr_nx = {addr_q[15:0], inbyte};

  spif_outsel u_outsel (
    .src(src_q), .mem_rdata(mem_rdata), .status(status_in),
    .rid_odd(ptr_q[0]), .jidx(jidx_q), .obyte(obyte)
  );

  always_comb begin
    phase_d = phase_q; src_d = src_q; pend_d = pend_q;
    bit_d = bit_q; byte_d = byte_q; sh_d = sh_q; opc_d = opc_q;
    addr_d = addr_q; data_d = data_q; ptr_d = ptr_q;
    ocnt_d = ocnt_q; osh_d = osh_q; so_d = so_q; jidx_d = jidx_q;
    cv_d = 1'b0; cop_d = cop_q; caddr_d = caddr_q; cdata_d = cdata_q;
    if (cs_n_s) begin
      if (cs_rise && phase_q == PH_DONE) begin
        cv_d = 1'b1; cop_d = pend_q; caddr_d = addr_q; cdata_d = data_q;
      end
      phase_d = PH_OPC; pend_d = OP_NONE; bit_d = '0; byte_d = '0;
      ocnt_d = '0; so_d = 1'b0; data_d = '0; jidx_d = '0;
    end else begin
      if (rise) begin
        sh_d  = inbyte;
        bit_d = bit_q + 3'd1;
        if (phase_q == PH_DONE) begin
          phase_d = PH_IGN;
        end else if (bit_q == 3'd7) begin
          case (phase_q)
            PH_OPC: begin
              opc_d = inbyte; byte_d = '0;
              case (inbyte)
                C_READ, C_FREAD, C_SECT, C_BLK, C_PROG, C_AAI, C_RID:
                  phase_d = PH_ADDR;
                C_SIG:   phase_d = status_in[0] ? PH_IGN : PH_ADDR;
                C_CHIPA, C_CHIPB: begin pend_d = OP_CHIP; phase_d = PH_DONE; end
                C_WEN:   begin pend_d = OP_WEN;  phase_d = PH_DONE; end
                C_WDIS:  begin pend_d = OP_WDIS; phase_d = PH_DONE; end
                C_EWST:  begin pend_d = OP_EWST; phase_d = PH_DONE; end
                C_EBSY:  begin pend_d = OP_EBSY; phase_d = PH_DONE; end
                C_DBSY:  begin pend_d = OP_DBSY; phase_d = PH_DONE; end
                C_WRST:  begin pend_d = OP_WRST; phase_d = PH_DIN;  end
                C_RDST:  begin src_d = SRC_STAT; phase_d = PH_OUT;  end
                C_JID:   begin src_d = SRC_JID;  phase_d = PH_OUT;  end
                default: phase_d = PH_IGN;
              endcase
            end
            PH_ADDR: begin
              addr_d = addr_nx;
              byte_d = byte_q + 2'd1;
              if (byte_q == 2'(AB - 1)) begin
                ptr_d  = addr_nx[ADDR_W-1:0];
                byte_d = '0;
                case (opc_q)
                  C_READ:  begin src_d = SRC_MEM; phase_d = PH_OUT; end
                  C_FREAD: phase_d = PH_DUMMY;
                  C_SECT:  begin pend_d = OP_SECT; phase_d = PH_DONE; end
                  C_BLK:   begin pend_d = OP_BLK;  phase_d = PH_DONE; end
                  C_PROG:  begin pend_d = OP_PROG; phase_d = PH_DIN;  end
                  C_AAI:   begin pend_d = OP_AAI;  phase_d = PH_DIN;  end
                  default: begin src_d = SRC_RID; phase_d = PH_OUT; end
                endcase
              end
            end
            PH_DUMMY: begin src_d = SRC_MEM; phase_d = PH_OUT; end
            PH_DIN: begin
              data_d = {data_q[7:0], inbyte};
              byte_d = byte_q + 2'd1;
              if (pend_q != OP_AAI || byte_q == 2'd1) phase_d = PH_DONE;
            end
            default: ;
          endcase
        end
      end
      if (fall && phase_q == PH_OUT) begin
        ocnt_d = ocnt_q + 3'd1;
        if (ocnt_q == 3'd0) begin
          so_d  = obyte[7];
          osh_d = {obyte[6:0], 1'b0};
          case (src_q)
            SRC_MEM: ptr_d = ptr_q + 1'b1;
            SRC_RID: ptr_d = {ptr_q[ADDR_W-1:1], ~ptr_q[0]};
            SRC_JID: if (jidx_q != 2'd3) jidx_d = jidx_q + 2'd1;
            default: ;
          endcase
        end else begin
          so_d  = osh_q[7];
          osh_d = {osh_q[6:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_OPC; src_q <= SRC_MEM; pend_q <= OP_NONE; cop_q <= OP_NONE;
      bit_q <= '0; byte_q <= '0; sh_q <= '0; opc_q <= '0;
      addr_q <= '0; data_q <= '0; ptr_q <= '0; ocnt_q <= '0; osh_q <= '0;
      so_q <= 1'b0; jidx_q <= '0; cv_q <= 1'b0; caddr_q <= '0; cdata_q <= '0;
      sck_q <= 1'b0; cs_q <= 1'b1;
    end else begin
      phase_q <= phase_d; src_q <= src_d; pend_q <= pend_d; cop_q <= cop_d;
      bit_q <= bit_d; byte_q <= byte_d; sh_q <= sh_d; opc_q <= opc_d;
      addr_q <= addr_d; data_q <= data_d; ptr_q <= ptr_d; ocnt_q <= ocnt_d;
      osh_q <= osh_d; so_q <= so_d; jidx_q <= jidx_d; cv_q <= cv_d;
      caddr_q <= caddr_d; cdata_q <= cdata_d; sck_q <= sck_s; cs_q <= cs_n_s;
    end
  end

  assign so_out    = so_q;
  assign so_oe     = ~cs_n_s & ~paused & (phase_q == PH_OUT);
  assign mem_addr  = ptr_q;
  assign mem_rd    = ~cs_n_s & (phase_q == PH_OUT) & (src_q == SRC_MEM);
  assign cmd_valid = cv_q;
  assign cmd_op    = cop_q;
  assign cmd_addr  = caddr_q;
  assign cmd_data  = cdata_q;
endmodule

// File: rtl/spif_frontend_chk.sv
module spif_frontend_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [3:0] cmd_op,
  input logic       so_oe,
  input logic       paused,
  input logic       cs_n_s,
  input logic       hold_q
);
  // R8
  cmd_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
  // R8
  cmd_on_cs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cs_n_s && cmd_op != 4'd0));
  // R11
  paused_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    paused |-> !so_oe);
  // R13
  drive_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    so_oe |-> !cs_n_s);
  // R12
  cs_clears_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> !hold_q);
endmodule

bind spif_frontend spif_frontend_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .so_oe(so_oe), .paused(paused), .cs_n_s(cs_n_s), .hold_q(hold_q)
);

// File: tb/spif_frontend_tb_top.sv
module spif_frontend_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, sck, cs_n, si, hold_n;
  logic so_out, so_oe, mem_rd, cmd_valid;
  logic [18:0] mem_addr;
  logic [7:0]  mem_rdata, status_in;
  logic [3:0]  cmd_op;
  logic [23:0] cmd_addr;
  logic [15:0] cmd_data;

  int n_chk = 0, n_bad = 0, ncmd = 0;
  logic [3:0]  l_op = '0;
  logic [23:0] l_addr = '0;
  logic [15:0] l_data = '0;

  function automatic logic [7:0] memf(input logic [18:0] a);
    return a[7:0] ^ {5'b0, a[18:16]} ^ 8'hA5;
  endfunction

  assign mem_rdata = memf(mem_addr);

  spif_frontend dut_i (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_si(si),
    .spi_hold_n(hold_n), .so_out(so_out), .so_oe(so_oe), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_rdata(mem_rdata), .status_in(status_in),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );

  always @(posedge clk) if (cmd_valid) begin
    ncmd   <= ncmd + 1;
    l_op   <= cmd_op;
    l_addr <= cmd_addr;
    l_data <= cmd_data;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sbit(input logic b, output logic o);
    si = b; wclk(8); o = so_out; sck = 1'b1; wclk(8); sck = 1'b0;
  endtask

  task automatic sbyte(input logic [7:0] tx, output logic [7:0] rx);
    logic o;
    for (int i = 7; i >= 0; i--) begin
      sbit(tx[i], o);
      rx[i] = o;
    end
  endtask

  task automatic send(input logic [7:0] b);
    logic [7:0] d;
    sbyte(b, d);
  endtask

  task automatic send_addr(input logic [23:0] a);
    send(a[23:16]); send(a[15:8]); send(a[7:0]);
  endtask

  task automatic cs_on;  cs_n = 1'b0; wclk(8); endtask
  task automatic cs_off; wclk(4); cs_n = 1'b1; wclk(12); endtask

  task automatic t_reset;
    chk("R13 so_oe after reset", so_oe, 0);
    chk("R8 cmd_valid after reset", cmd_valid, 0);
  endtask

  task automatic t_read(input logic [7:0] opc, input logic [23:0] a, input int n, input string tag);
    logic [7:0] rx;
    logic [18:0] p;
    p = a[18:0];
    cs_on; send(opc); send_addr(a);
    if (opc == 8'h0B) send(8'h00);
    for (int i = 0; i < n; i++) begin
      sbyte(8'h00, rx);
      chk(tag, rx, memf(p));
      p = p + 19'd1;
    end
    cs_off;
    chk("R13 so_oe idle after read", so_oe, 0);
  endtask

  task automatic t_rdsr;
    logic [7:0] rx;
    status_in = 8'h9C;
    cs_on; send(8'h05);
    sbyte(8'h00, rx); chk("R4 status first", rx, 8'h9C);
    status_in = 8'h3C;
    sbyte(8'h00, rx); chk("R4 status repeat", rx, 8'h3C);
    cs_off;
    status_in = 8'h00;
  endtask

  task automatic t_jedec;
    logic [7:0] rx;
    logic [7:0] exp [4] = '{8'h8C, 8'h20, 8'h13, 8'h00};
    cs_on; send(8'h9F);
    for (int i = 0; i < 4; i++) begin
      sbyte(8'h00, rx); chk("R5 jedec id byte", rx, exp[i]);
    end
    cs_off;
  endtask

  task automatic t_rid(input logic [7:0] opc, input logic [23:0] a, input string tag);
    logic [7:0] rx;
    logic odd;
    odd = a[0];
    cs_on; send(opc); send_addr(a);
    for (int i = 0; i < 3; i++) begin
      sbyte(8'h00, rx); chk(tag, rx, odd ? 8'h12 : 8'h8C);
      odd = ~odd;
    end
    cs_off;
  endtask

  task automatic t_res_busy;
    int c0;
    logic [7:0] rx;
    c0 = ncmd;
    status_in = 8'h01;
    cs_on; send(8'hAB); send_addr(24'h0); sbyte(8'h00, rx);
    chk("R7 signature refused when busy", so_oe, 0);
    cs_off;
    chk("R7 no command when busy", ncmd, c0);
    status_in = 8'h00;
    t_rid(8'hAB, 24'h000000, "R7 signature when idle");
  endtask

  task automatic t_cmd(input logic [7:0] opc, input int na, input logic [23:0] a,
                       input int nd, input logic [15:0] d, input logic [3:0] eop,
                       input logic [15:0] edata, input string tag);
    int c0;
    c0 = ncmd;
    cs_on; send(opc);
    if (na != 0) send_addr(a);
    if (nd > 1) send(d[15:8]);
    if (nd > 0) send(d[7:0]);
    chk({tag, " no strobe before CS rise"}, ncmd, c0);
    cs_off;
    chk({tag, " one strobe"}, ncmd, c0 + 1);
    chk({tag, " op"}, l_op, eop);
    if (na != 0) chk({tag, " addr"}, l_addr, a);
    chk({tag, " data"}, l_data, edata);
  endtask

  task automatic t_abort;
    int c0;
    logic o;
    c0 = ncmd;
    cs_on;
    for (int i = 0; i < 5; i++) sbit(1'b0, o);
    cs_off;
    chk("R9 partial opcode aborted", ncmd, c0);
    cs_on; send(8'hC7); sbit(1'b0, o); cs_off;
    chk("R9 extra clock cancels", ncmd, c0);
    t_cmd(8'h06, 0, 24'h0, 0, 16'h0, 4'd1, 16'h0, "R9 clean after abort");
  endtask

  task automatic t_unknown;
    int c0;
    logic [7:0] rx;
    c0 = ncmd;
    cs_on; send(8'hFF); sbyte(8'h00, rx);
    chk("R10 unknown opcode undriven", so_oe, 0);
    sbyte(8'h06, rx);
    cs_off;
    chk("R10 unknown opcode no command", ncmd, c0);
  endtask

  task automatic t_hold_mid;
    logic [7:0] rx;
    logic o;
    cs_on; send(8'h03); send_addr(24'h000230);
    sbyte(8'h00, rx); chk("R11 byte before pause", rx, memf(19'h230));
    for (int i = 7; i >= 4; i--) begin sbit(1'b0, o); rx[i] = o; end
    wclk(8); hold_n = 1'b0; wclk(8);
    chk("R11 paused undriven", so_oe, 0);
    for (int i = 0; i < 3; i++) begin
      si = ~si; sck = 1'b1; wclk(8); sck = 1'b0; wclk(8);
    end
    hold_n = 1'b1; wclk(8);
    chk("R11 drive resumes", so_oe, 1);
    for (int i = 3; i >= 0; i--) begin sbit(1'b0, o); rx[i] = o; end
    chk("R11 byte across pause", rx, memf(19'h231));
    sbyte(8'h00, rx); chk("R11 byte after pause", rx, memf(19'h232));
    cs_off;
  endtask

  task automatic t_hold_late;
    logic [7:0] rx;
    logic o;
    cs_on; send(8'h03); send_addr(24'h000100);
    sbyte(8'h00, rx);
    sbit(1'b0, o);
    si = 1'b0; wclk(8); sck = 1'b1; wclk(8);
    hold_n = 1'b0; wclk(8);
    chk("R11 pause deferred while SCK high", so_oe, 1);
    sck = 1'b0; wclk(8);
    chk("R11 pause taken at SCK low", so_oe, 0);
    cs_n = 1'b1; wclk(12);
    hold_n = 1'b1; wclk(8);
    status_in = 8'h5A;
    cs_on; send(8'h05); sbyte(8'h00, rx);
    chk("R12 fresh decode after CS in pause", rx, 8'h5A);
    cs_off;
    status_in = 8'h00;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    wclk(200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_n = 1'b0; sck = 1'b0; cs_n = 1'b1; si = 1'b0; hold_n = 1'b1; status_in = 8'h00;
    wclk(5); rst_n = 1'b1; wclk(5);
    t_reset();
    t_read(8'h03, 24'h000010, 3, "R1 read stream");
    t_read(8'h03, 24'h07FFFF, 2, "R2 read wrap");
    t_read(8'h0B, 24'h012340, 3, "R3 fast read");
    t_read(8'h0B, 24'h07FFFE, 3, "R2 fast read wrap");
    t_rdsr();
    t_jedec();
    t_rid(8'h90, 24'h000001, "R6 read id from odd");
    t_rid(8'h90, 24'h000000, "R6 read id from even");
    t_res_busy();
    t_cmd(8'h06, 0, 24'h0, 0, 16'h0, 4'd1, 16'h0, "R8 write enable");
    t_cmd(8'h04, 0, 24'h0, 0, 16'h0, 4'd2, 16'h0, "R8 write disable");
    t_cmd(8'h20, 1, 24'h012345, 0, 16'h0, 4'd7, 16'h0, "R8 sector erase");
    t_cmd(8'hD8, 1, 24'h050000, 0, 16'h0, 4'd8, 16'h0, "R8 block erase");
    t_cmd(8'h02, 1, 24'h000040, 1, 16'h005A, 4'd5, 16'h005A, "R8 byte program");
    t_cmd(8'hAD, 1, 24'h000100, 2, 16'h1122, 4'd6, 16'h1122, "R8 word program");
    t_cmd(8'h01, 0, 24'h0, 1, 16'h008C, 4'd4, 16'h008C, "R8 status write");
    t_cmd(8'h60, 0, 24'h0, 0, 16'h0, 4'd9, 16'h0, "R8 chip erase");
    t_cmd(8'hC7, 0, 24'h0, 0, 16'h0, 4'd9, 16'h0, "R8 chip erase alt");
    t_cmd(8'h70, 0, 24'h0, 0, 16'h0, 4'd10, 16'h0, "R8 busy on SO");
    t_abort();
    t_unknown();
    t_hold_mid();
    t_hold_late();
    summary();
  end
endmodule